// File: doc/BRIEF.md
# GPIO Pin Write-Protection Unit

This block guards the pin registers of a banked GPIO controller against stray software writes. Each bank has a lock word with one bit per pin. A set bit freezes that pin's control register and that pin's bit in the output set and clear registers. The lock words can change only through a two-step sequence. Software first writes a fixed password to a dedicated register. The very next bus write may then load one bank's lock word.

The block sits beside the register file on a simple bus with valid, write, address and data signals. It decodes each write to a pin control register or to an output set/clear register. For that write it drives per-pin write enables that the register file uses in place of its own raw decode. To change one pin, software reads the bank's lock word, edits that one bit, writes the password again and writes the edited word back.

Top module: `gpio_pin_lock`

## Requirements
- R1: After reset every lock bit is 1, so `lock_state` is all ones, and the block is disarmed.
- R2: A bus write of 0x00A5A501 to offset 0x520 arms the block. If the next bus write targets a lock register (offset 0x500 + 4*n), its whole data word becomes bank n's lock word: all ones locks every pin of the bank and all zeros unlocks every pin.
- R3: A write to a lock register while the block is disarmed leaves every lock bit unchanged.
- R4: Any bus write that is not the correct password disarms the block, including a password write with a wrong value and a write to a pin register. Bus reads do not change the armed state.
- R5: Arming covers exactly one write. After a lock register has been loaded, a second lock write that has no fresh password in front of it is ignored.
- R6: Bit k of bank n's lock word locks pin 32*n + k. A read at 0x500 + 4*n returns that word on `bus_rdata` in the same cycle, and `lock_state[32*n+k]` shows the same bit.
- R7: A write to pin p's control register (offset 0x100 + 4*p) raises `ctrl_wr_en[p]` in the same cycle, and no other bit, exactly when pin p is unlocked.
- R8: A write to the output set register (0x040 + 4*n) or to the output clear register (0x060 + 4*n) drives bits 32*n..32*n+31 of `out_set_en` or `out_clr_en` with the write data ANDed with the inverse of the lock word. Every other bit stays 0.
- R9: No write enable is raised unless `bus_valid` and `bus_write` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Lock word of the addressed bank on a lock-register read, otherwise 0 |
| lock_state | output | NUM_BANKS*32 (256) | Current lock bit of every pin |
| ctrl_wr_en | output | NUM_BANKS*32 (256) | Qualified write enable for each pin control register |
| out_set_en | output | NUM_BANKS*32 (256) | Qualified per-pin set enables |
| out_clr_en | output | NUM_BANKS*32 (256) | Qualified per-pin clear enables |

## Verification
The embedded properties check, on every cycle, the rules that hold cycle by cycle:
- a control enable is one-hot and never reaches a locked pin;
- set and clear enables never reach a locked pin, and none is raised without a bus write;
- after reset the lock words are all ones;
- a bank word changes only on a qualified load, and then takes exactly the written value;
- a qualified load is never followed directly by another.

The arming sequence as a whole can be shown only by the bench's scenarios. Those scenarios cover a rejected write with no password, a wrong password value, a disarming pin write, a read that keeps the block armed and a read-modify-write of a single pin. The bench also sweeps every pin's control enable and every bank's set and clear masks against a lock model it keeps itself.

// File: rtl/gpl_pkg.sv
// Package: shared constants and the decoded-access type of the pin lock unit.
// Assumes at most 8 banks of 32 pins, so a pin index fits in 8 bits.
package gpl_pkg;
    localparam int unsigned PINS_PER_BANK = 32;
    localparam int unsigned MAX_BANKS     = 8;
    localparam int unsigned BANK_IDX_W    = $clog2(MAX_BANKS);
    localparam int unsigned PIN_IDX_W     = $clog2(MAX_BANKS * PINS_PER_BANK);

    // Result of decoding one bus address; at most one window flag is set.
    typedef struct packed {
        logic                  pwd;
        logic                  lock;
        logic                  ctrl;
        logic                  oset;
        logic                  oclr;
        logic [BANK_IDX_W-1:0] bank;
        logic [PIN_IDX_W-1:0]  pin;
    } gpl_hit_t;
endpackage

// File: rtl/gpl_addr_decode.sv
// Address decoder: classifies a byte offset into password, lock, pin-control,
// output-set or output-clear windows and extracts the bank or pin index.
// Assumes word-aligned windows that do not overlap; unaligned offsets match nothing.
module gpl_addr_decode
    import gpl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned PWD_OFS   = 'h520,
    parameter int unsigned LOCK_BASE = 'h500,
    parameter int unsigned CTRL_BASE = 'h100,
    parameter int unsigned SET_BASE  = 'h040,
    parameter int unsigned CLR_BASE  = 'h060
) (
    input  logic [ADDR_W-1:0] addr,
    output gpl_hit_t          hit
);
    localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK;
    localparam logic [ADDR_W-1:0] PWD_A   = ADDR_W'(PWD_OFS);
    localparam logic [ADDR_W-1:0] LOCK_LO = ADDR_W'(LOCK_BASE);
    localparam logic [ADDR_W-1:0] LOCK_HI = ADDR_W'(LOCK_BASE + 4 * NUM_BANKS);
    localparam logic [ADDR_W-1:0] CTRL_LO = ADDR_W'(CTRL_BASE);
    localparam logic [ADDR_W-1:0] CTRL_HI = ADDR_W'(CTRL_BASE + 4 * NUM_PINS);
    localparam logic [ADDR_W-1:0] SET_LO  = ADDR_W'(SET_BASE);
    localparam logic [ADDR_W-1:0] SET_HI  = ADDR_W'(SET_BASE + 4 * NUM_BANKS);
    localparam logic [ADDR_W-1:0] CLR_LO  = ADDR_W'(CLR_BASE);
    localparam logic [ADDR_W-1:0] CLR_HI  = ADDR_W'(CLR_BASE + 4 * NUM_BANKS);

    logic aligned;

    // Purpose: window matching and index extraction for the current address.
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        hit      = '0;
        hit.pwd  = (addr == PWD_A);
        hit.lock = aligned && (addr >= LOCK_LO) && (addr < LOCK_HI);
        hit.ctrl = aligned && (addr >= CTRL_LO) && (addr < CTRL_HI);
        hit.oset = aligned && (addr >= SET_LO)  && (addr < SET_HI);
        hit.oclr = aligned && (addr >= CLR_LO)  && (addr < CLR_HI);
        if (hit.lock)
            hit.bank = BANK_IDX_W'((addr - LOCK_LO) >> 2);
        else if (hit.oset)
            hit.bank = BANK_IDX_W'((addr - SET_LO) >> 2);
        else if (hit.oclr)
            hit.bank = BANK_IDX_W'((addr - CLR_LO) >> 2);
        if (hit.ctrl)
            hit.pin = PIN_IDX_W'((addr - CTRL_LO) >> 2);
    end
endmodule

// File: rtl/gpl_arm_ctrl.sv
// Arming control: a correct password write arms the unit for the next bus
// write only; every other write clears the armed state, and reads leave it.
// Assumes wr_stb is high for one cycle per bus write.
module gpl_arm_ctrl #(
    parameter logic [31:0] PASSWORD = 32'h00A5_A501
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic        hit_pwd,
    input  logic        hit_lock,
    input  logic [31:0] wdata,
    output logic        lock_load
);
    logic armed_q;
    logic pwd_match;

    // Purpose: recognise a password write carrying the exact arming value.
    always_comb pwd_match = wr_stb && hit_pwd && (wdata == PASSWORD);

    // Purpose: one-shot armed flag, re-evaluated on every bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (wr_stb)
            armed_q <= pwd_match;
    end

    // Purpose: a lock register may be loaded only by the write right after arming.
    always_comb lock_load = armed_q && wr_stb && hit_lock;

    AST_DISARM_ON_OTHER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !pwd_match) |=> !lock_load); // R4
    AST_ONE_LOAD_PER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        lock_load |=> !lock_load); // R5
endmodule

// File: rtl/gpl_lock_bank.sv
// Lock word of one bank: 32 lock bits, all set at reset, replaced as a whole
// word when a qualified load addresses this bank.
// Assumes load is already gated by the arming control.
module gpl_lock_bank
    import gpl_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [BANK_IDX_W-1:0]    bank_sel,
    input  logic [PINS_PER_BANK-1:0] wdata,
    output logic [PINS_PER_BANK-1:0] lock_q
);
    logic mine;

    // Purpose: this bank is the target of the current qualified load.
    always_comb mine = load && (bank_sel == BANK_IDX_W'(BANK_IDX));

    // Purpose: lock word storage, reset to fully locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '1;
        else if (mine)
            lock_q <= wdata;
    end

    AST_LOCKED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&lock_q)); // R1
    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && bank_sel == BANK_IDX_W'(BANK_IDX)) |=> $stable(lock_q)); // R3
    AST_LOCK_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bank_sel == BANK_IDX_W'(BANK_IDX)) |=> (lock_q == $past(wdata))); // R2
endmodule

// File: rtl/gpl_wr_qualify.sv
// Write qualifier: turns a decoded bus write into per-pin enables for the
// pin control registers and the output set/clear registers, masked by locks.
// Assumes the decoder flags at most one window per access.
module gpl_wr_qualify
    import gpl_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  gpl_hit_t            hit,
    input  logic [31:0]         wdata,
    input  logic [NUM_PINS-1:0] lock,
    output logic [NUM_PINS-1:0] ctrl_wr_en,
    output logic [NUM_PINS-1:0] set_en,
    output logic [NUM_PINS-1:0] clr_en
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_set;
        logic sel_clr;
        logic [PINS_PER_BANK-1:0] free;

        // Purpose: set/clear lane enables for bank b, locked pins masked off.
        always_comb begin
            sel_set = wr_stb && hit.oset && (hit.bank == BANK_IDX_W'(b));
            sel_clr = wr_stb && hit.oclr && (hit.bank == BANK_IDX_W'(b));
            free    = wdata & ~lock[b*PINS_PER_BANK +: PINS_PER_BANK];
            set_en[b*PINS_PER_BANK +: PINS_PER_BANK] = sel_set ? free : '0;
            clr_en[b*PINS_PER_BANK +: PINS_PER_BANK] = sel_clr ? free : '0;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // Purpose: control-register enable for pin p when it is unlocked.
        always_comb ctrl_wr_en[p] = wr_stb && hit.ctrl
                                    && (hit.pin == PIN_IDX_W'(p)) && !lock[p];
    end

    AST_CTRL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_wr_en)); // R7
    AST_CTRL_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_en & lock) == '0); // R7
    AST_OUT_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_en | clr_en) & lock) == '0); // R8
    AST_QUIET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> ((ctrl_wr_en | set_en | clr_en) == '0)); // R9
endmodule

// File: rtl/gpio_pin_lock.sv
// Top: password-armed per-pin write protection for a banked GPIO register file.
// Decodes the bus, holds one lock word per bank, and qualifies pin writes.
// Assumes a single-cycle bus; read data is combinational.
module gpio_pin_lock
    import gpl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_BANKS = 8,
    parameter logic [31:0] PASSWORD  = 32'h00A5_A501,
    parameter int unsigned PWD_OFS   = 'h520,
    parameter int unsigned LOCK_BASE = 'h500,
    parameter int unsigned CTRL_BASE = 'h100,
    parameter int unsigned SET_BASE  = 'h040,
    parameter int unsigned CLR_BASE  = 'h060,
    localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] lock_state,
    output logic [NUM_PINS-1:0] ctrl_wr_en,
    output logic [NUM_PINS-1:0] out_set_en,
    output logic [NUM_PINS-1:0] out_clr_en
);
    gpl_hit_t hit;
    logic     wr_stb;
    logic     rd_stb;
    logic     lock_load;

    // Purpose: split the bus access into write and read strobes.
    always_comb begin
        wr_stb = bus_valid && bus_write;
        rd_stb = bus_valid && !bus_write;
    end

    gpl_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .PWD_OFS(PWD_OFS),
        .LOCK_BASE(LOCK_BASE), .CTRL_BASE(CTRL_BASE),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    gpl_arm_ctrl #(.PASSWORD(PASSWORD)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .hit_pwd   (hit.pwd),
        .hit_lock  (hit.lock),
        .wdata     (bus_wdata),
        .lock_load (lock_load)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lock
        gpl_lock_bank #(.BANK_IDX(b)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (lock_load),
            .bank_sel (hit.bank),
            .wdata    (bus_wdata),
            .lock_q   (lock_state[b*PINS_PER_BANK +: PINS_PER_BANK])
        );
    end

    gpl_wr_qualify #(.NUM_BANKS(NUM_BANKS)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .hit        (hit),
        .wdata      (bus_wdata),
        .lock       (lock_state),
        .ctrl_wr_en (ctrl_wr_en),
        .set_en     (out_set_en),
        .clr_en     (out_clr_en)
    );

    // Purpose: return the addressed bank's lock word on a lock-register read.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (rd_stb && hit.lock && hit.bank == BANK_IDX_W'(b))
                bus_rdata = lock_state[b*PINS_PER_BANK +: PINS_PER_BANK];
    end
endmodule

// File: tb/gpio_pin_lock_tb_top.sv
// Bench: sweeps every pin and bank of the default configuration against a
// lock model derived from the requirements.
module gpio_pin_lock_tb_top;
    localparam int NB   = 8;
    localparam int NP   = NB * 32;
    localparam logic [31:0] PASS = 32'h00A5_A501;
    localparam logic [11:0] PWD  = 12'h520;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] lock_state, ctrl_wr_en, out_set_en, out_clr_en;

    int n_checks = 0;
    int n_errors = 0;
    logic [NP-1:0] m_lock;
    logic          m_armed;

    always #2.5 clk = ~clk;

    gpio_pin_lock dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_state(lock_state), .ctrl_wr_en(ctrl_wr_en),
        .out_set_en(out_set_en), .out_clr_en(out_clr_en)
    );

    function automatic logic [11:0] lock_addr(input int b);
        return 12'(12'h500 + 4 * b);
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge and update the model as the
    // requirements describe; the write takes effect at the next rising edge.
    task automatic access(input logic v, input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        if (v && w) begin
            for (int b = 0; b < NB; b++)
                if (m_armed && a == lock_addr(b)) m_lock[b*32 +: 32] = d;
            m_armed = (a == PWD) && (d == PASS);
        end
        #1;
    endtask

    task automatic idle();
        access(1'b0, 1'b0, 12'h0, 32'h0);
    endtask

    task automatic check_bank(input string tag, input int b);
        access(1'b1, 1'b0, lock_addr(b), 32'h0);
        check(tag, NP'(bus_rdata), NP'(m_lock[b*32 +: 32]));
    endtask

    function automatic logic [31:0] pat(input int b);
        return 32'hC3A5_5A3C ^ (32'h0101_0101 << b);
    endfunction

    initial begin
        m_lock  = '1;
        m_armed = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 lock_state after reset", lock_state, {NP{1'b1}});
        for (int b = 0; b < NB; b++) check_bank("R1 R6 reset readback", b);

        // R3: no password, write ignored (also shows reset is disarmed, R1)
        access(1'b1, 1'b1, lock_addr(0), 32'h0);
        idle();
        check("R3 unarmed lock write", lock_state, {NP{1'b1}});

        // R2 R6: armed loads, every bank
        for (int b = 0; b < NB; b++) begin
            access(1'b1, 1'b1, PWD, PASS);
            access(1'b1, 1'b1, lock_addr(b), pat(b));
        end
        idle();
        check("R2 R6 all banks loaded", lock_state, m_lock);
        for (int b = 0; b < NB; b++) check_bank("R6 bank readback", b);

        // R2: all zeros unlocks bank 0, all ones locks bank 7
        access(1'b1, 1'b1, PWD, PASS);
        access(1'b1, 1'b1, lock_addr(0), 32'h0);
        access(1'b1, 1'b1, PWD, PASS);
        access(1'b1, 1'b1, lock_addr(7), 32'hFFFF_FFFF);
        idle();
        check("R2 zeros and ones", lock_state, m_lock);

        // R5: second write after one arming is ignored
        access(1'b1, 1'b1, PWD, PASS);
        access(1'b1, 1'b1, lock_addr(1), 32'h0000_FFFF);
        access(1'b1, 1'b1, lock_addr(1), 32'hFFFF_0000);
        idle();
        check("R5 one shot", lock_state[63:32], NP'(32'h0000_FFFF));

        // R4: wrong password value disarms
        access(1'b1, 1'b1, PWD, PASS ^ 32'h1);
        access(1'b1, 1'b1, lock_addr(2), 32'h0);
        idle();
        check("R4 wrong password", lock_state, m_lock);
        check("R4 wrong password bank2", NP'(lock_state[95:64]), NP'(pat(2)));

        // R4: correct password followed by a pin write disarms
        access(1'b1, 1'b1, PWD, PASS);
        access(1'b1, 1'b1, 12'h100, 32'h1);
        access(1'b1, 1'b1, lock_addr(3), 32'h0);
        idle();
        check("R4 other write disarms", NP'(lock_state[127:96]), NP'(pat(3)));

        // R4: reads keep the armed state; R6 read-modify-write of one pin
        access(1'b1, 1'b1, PWD, PASS);
        check_bank("R4 R6 read while armed", 2);
        access(1'b1, 1'b1, lock_addr(2), pat(2) ^ 32'h0000_0020);
        idle();
        check("R4 R6 single pin flip", NP'(lock_state[95:64]), NP'(pat(2) ^ 32'h0000_0020));
        check("R6 model match", lock_state, m_lock);

        // R7: sweep every pin control register
        for (int p = 0; p < NP; p++) begin
            access(1'b1, 1'b1, 12'(12'h100 + 4 * p), 32'h1);
            check($sformatf("R7 ctrl pin %0d", p), ctrl_wr_en,
                  m_lock[p] ? '0 : (NP'(1) << p));
        end

        // R8: set and clear masks per bank
        for (int b = 0; b < NB; b++) begin
            logic [31:0]   d;
            logic [NP-1:0] e;
            d = 32'hF0F0_3C3C ^ (32'h0F0F_0F0F << b);
            e = '0;
            e[b*32 +: 32] = d & ~m_lock[b*32 +: 32];
            access(1'b1, 1'b1, 12'(12'h040 + 4 * b), d);
            check($sformatf("R8 set bank %0d", b), out_set_en, e);
            check($sformatf("R8 set bank %0d clr quiet", b), out_clr_en, '0);
            access(1'b1, 1'b1, 12'(12'h060 + 4 * b), d);
            check($sformatf("R8 clr bank %0d", b), out_clr_en, e);
            check($sformatf("R8 clr bank %0d set quiet", b), out_set_en, '0);
        end

        // R9: reads and invalid cycles raise no enable (pin 0 is unlocked)
        access(1'b1, 1'b0, 12'h100, 32'h1);
        check("R9 read ctrl", ctrl_wr_en, '0);
        access(1'b0, 1'b1, 12'h100, 32'h1);
        check("R9 invalid ctrl", ctrl_wr_en, '0);
        access(1'b0, 1'b1, 12'h040, 32'hFFFF_FFFF);
        check("R9 invalid set", out_set_en, '0);
        access(1'b1, 1'b1, 12'h100, 32'h1);
        check("R7 unlocked pin 0", ctrl_wr_en, NP'(1));
        idle();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule